// File: doc/BRIEF.md
# Processor Exception Vector Unit

This unit sits beside the trap logic of a 64-bit in-order pipeline. Each cycle it may see a reset request and a set of pending exceptions, one bit for each 5-bit exception code. It picks one winner. For that winner it works out the new program counter from a vector base and a vector offset. In the same step it updates the saved exception PC, the Cause register (code field and delay-slot flag) and the exception-level bit of Status. All results are registered and appear one cycle after the request.

The vector base comes from the bootstrap-vector control input. The offset depends on several things:
- the winning code;
- the interrupt-vector control bit, for interrupts;
- for TLB miss refills, whether the refill is taken at exception level zero and whether the faulting address lies in an extended 64-bit segment whose mode enable is on;
- for cache errors, the bootstrap setting, which selects their own dedicated location.

Nested exceptions, taken while the exception level is already raised, keep the saved PC and delay-slot flag of the first exception.

Top module: `exc_vector_unit`

## Requirements
- R1: The Cause code field (`cause_o` bits [6:2]) is written with the bit index of the winning bit of `pend_i`. Bit 0 is interrupt, 1 TLB modification, 2 TLB load miss, 3 TLB store miss, 4/5 address error load/store, 6 instruction bus error, 15 floating point, 18 coprocessor 2, 22 media extension, 23 watch, 24 machine check, 25 thread, 30 cache error.
- R2: After `rst_n` low, or one cycle after `rst_req_i`, `new_pc_o` is 0xFFFFFFFFBFC00000, the delay-slot flag (`cause_o` bit 31) is 0 and `exl_o` is 0. A reset request leaves `epc_o` and the code field unchanged and pulses `taken_o`.
- R3: The reset request beats every pending exception. Machine check (bit 24) beats every other pending bit. Otherwise the lowest set bit wins.
- R4: An interrupt (code 0) uses offset 0x200 when `iv_i` is 1, and 0x180 otherwise.
- R5: A TLB load or store miss (code 2 or 3) with `tlb_refill_i` set, taken while EXL is clear, uses offset 0x080 when the extended condition holds and 0x000 otherwise. The extended condition is: `bad_seg_i`=0 with `ux_i`, `bad_seg_i`=1 with `sx_i`, or `bad_seg_i`=3 with `kx_i`. Segment 2 never meets it.
- R6: Every other case uses offset 0x180. This includes a refill taken while EXL is already set, a TLB miss that is not a refill, and any other code.
- R7: A cache error (code 30) vectors to 0xFFFFFFFFBFC00300 when `bev_i` is 1 and to 0xFFFFFFFFA0000100 when it is 0.
- R8: `new_pc_o` equals base plus offset. The base is 0xFFFFFFFF80000000 when `bev_i` is 0 and 0xFFFFFFFFBFC00200 when it is 1.
- R9: When EXL is clear on entry, `epc_o` becomes `fault_pc_i` (or `fault_pc_i`-4 if `in_delay_slot_i` is 1), and the delay-slot flag takes `in_delay_slot_i`. When EXL is set on entry, both keep their values.
- R10: Each taken exception sets `exl_o`, writes the code and pulses `taken_o`, all visible one cycle after the request.
- R11: A cycle with no reset request and no pending bit changes no output, and `taken_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| rst_req_i | input | 1 | Reset exception request |
| pend_i | input | 32 | Pending exceptions, one bit per code |
| fault_pc_i | input | 64 | PC of the faulting instruction |
| in_delay_slot_i | input | 1 | Faulting instruction sits in a branch delay slot |
| tlb_refill_i | input | 1 | TLB miss is a refill |
| bad_seg_i | input | 2 | Bits [63:62] of the bad virtual address |
| bev_i | input | 1 | Bootstrap vector select |
| iv_i | input | 1 | Dedicated interrupt vector enable |
| ux_i | input | 1 | User extended addressing enable |
| sx_i | input | 1 | Supervisor extended addressing enable |
| kx_i | input | 1 | Kernel extended addressing enable |
| taken_o | output | 1 | One-cycle pulse: an exception or reset was applied |
| new_pc_o | output | 64 | Next program counter |
| epc_o | output | 64 | Saved exception PC |
| cause_o | output | 32 | Cause: code at [6:2], delay-slot flag at [31] |
| exl_o | output | 1 | Exception level bit |

## Verification
Prioritisation and reset handling can fall in the same cycle as vector selection. The bench raises `rst_req_i` together with pending bits and checks that the reset vector wins and that the saved PC stays put. It also presents many multi-bit pending masks, with and without bit 24, and compares the reported code against the lowest set bit computed in the bench. A second overlap is the EXL-dependent refill offset: the bench sweeps every code under both EXL states, reaching the set state through a prior exception, and checks both the offset and the preserved saved PC.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
    localparam int EXC_INT    = 0;
    localparam int EXC_TLBL   = 2;
    localparam int EXC_TLBS   = 3;
    localparam int EXC_MCHECK = 24;
    localparam int EXC_CACHE  = 30;

    localparam int OFF_W = 30;
    localparam logic [OFF_W-1:0] OFF_REFILL    = 30'h000;
    localparam logic [OFF_W-1:0] OFF_XREFILL   = 30'h080;
    localparam logic [OFF_W-1:0] OFF_CERR_BOOT = 30'h100;
    localparam logic [OFF_W-1:0] OFF_GENERAL   = 30'h180;
    localparam logic [OFF_W-1:0] OFF_IRQ       = 30'h200;
    localparam logic [OFF_W-1:0] OFF_CERR_ABS  = 30'h2000_0100;

    localparam logic [31:0] BASE_NORM_LO = 32'h8000_0000;
    localparam logic [31:0] BASE_BOOT_LO = 32'hBFC0_0200;
    localparam logic [31:0] RESET_LO     = 32'hBFC0_0000;
endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
    import exc_vec_pkg::*;
#(
    parameter int NCODES = 32,
    parameter int CODE_W = $clog2(NCODES)
) (
    input  logic [NCODES-1:0] pend_i,
    output logic              any_o,
    output logic [CODE_W-1:0] code_o
);
    always_comb begin
        any_o  = |pend_i;
        code_o = '0;
        for (int k = NCODES - 1; k >= 0; k--) begin
            if (pend_i[k]) code_o = CODE_W'(k);
        end
        if (pend_i[EXC_MCHECK]) code_o = CODE_W'(EXC_MCHECK);
    end

    always_comb begin
        if (any_o) begin
            AST_GRANT_PENDING: assert (pend_i[code_o]); // R3
        end
    end
endmodule

// File: rtl/exc_vec_calc.sv
module exc_vec_calc
    import exc_vec_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int CODE_W      = 5,
    parameter bit EXT_REGIONS = 1'b1
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              refill_i,
    input  logic              exl_i,
    input  logic              iv_i,
    input  logic              bev_i,
    input  logic [1:0]        seg_i,
    input  logic              ux_i,
    input  logic              sx_i,
    input  logic              kx_i,
    output logic [XLEN-1:0]   new_pc_o
);
    localparam logic [XLEN-1:0] BASE_NORM = {{(XLEN-32){1'b1}}, BASE_NORM_LO};
    localparam logic [XLEN-1:0] BASE_BOOT = {{(XLEN-32){1'b1}}, BASE_BOOT_LO};

    logic             ext_seg;
    logic             is_tlb_miss;
    logic [OFF_W-1:0] offset;

    generate
        if (EXT_REGIONS) begin : g_ext
            always_comb begin
                case (seg_i)
                    2'd0:    ext_seg = ux_i;
                    2'd1:    ext_seg = sx_i;
                    2'd3:    ext_seg = kx_i;
                    default: ext_seg = 1'b0;
                endcase
            end
        end else begin : g_noext
            assign ext_seg = 1'b0;
        end
    endgenerate

    assign is_tlb_miss = (code_i == CODE_W'(EXC_TLBL)) || (code_i == CODE_W'(EXC_TLBS));

    always_comb begin
        offset = OFF_GENERAL;
        if (code_i == CODE_W'(EXC_INT)) begin
            offset = iv_i ? OFF_IRQ : OFF_GENERAL;
        end else if (is_tlb_miss && refill_i && !exl_i) begin
            offset = ext_seg ? OFF_XREFILL : OFF_REFILL;
        end else if (code_i == CODE_W'(EXC_CACHE)) begin
            offset = bev_i ? OFF_CERR_BOOT : OFF_CERR_ABS;
        end
        new_pc_o = (bev_i ? BASE_BOOT : BASE_NORM) + XLEN'(offset);
    end

    always_comb begin
        AST_VEC_ALIGNED: assert (new_pc_o[6:0] == 7'd0); // R8
    end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
    import exc_vec_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int NCODES      = 32,
    parameter int CODE_W      = $clog2(NCODES),
    parameter bit EXT_REGIONS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_req_i,
    input  logic [NCODES-1:0] pend_i,
    input  logic [XLEN-1:0]   fault_pc_i,
    input  logic              in_delay_slot_i,
    input  logic              tlb_refill_i,
    input  logic [1:0]        bad_seg_i,
    input  logic              bev_i,
    input  logic              iv_i,
    input  logic              ux_i,
    input  logic              sx_i,
    input  logic              kx_i,
    output logic              taken_o,
    output logic [XLEN-1:0]   new_pc_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [31:0]       cause_o,
    output logic              exl_o
);
    localparam logic [XLEN-1:0] RESET_PC  = {{(XLEN-32){1'b1}}, RESET_LO};
    localparam logic [XLEN-1:0] INSN_SIZE = XLEN'(4);
    localparam int              BD_BIT    = 31;
    localparam int              CODE_LSB  = 2;

    typedef struct packed {
        logic [XLEN-1:0]   pc;
        logic [XLEN-1:0]   epc;
        logic [CODE_W-1:0] code;
        logic              bd;
        logic              exl;
        logic              taken;
    } state_t;

    state_t            st_d, st_q;
    logic              any_pend;
    logic [CODE_W-1:0] win_code;
    logic [XLEN-1:0]   vec_pc;

    exc_prio_sel #(
        .NCODES (NCODES),
        .CODE_W (CODE_W)
    ) u_prio (
        .pend_i (pend_i),
        .any_o  (any_pend),
        .code_o (win_code)
    );

    exc_vec_calc #(
        .XLEN        (XLEN),
        .CODE_W      (CODE_W),
        .EXT_REGIONS (EXT_REGIONS)
    ) u_vec (
        .code_i   (win_code),
        .refill_i (tlb_refill_i),
        .exl_i    (st_q.exl),
        .iv_i     (iv_i),
        .bev_i    (bev_i),
        .seg_i    (bad_seg_i),
        .ux_i     (ux_i),
        .sx_i     (sx_i),
        .kx_i     (kx_i),
        .new_pc_o (vec_pc)
    );

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        if (rst_req_i) begin
            st_d.pc    = RESET_PC;
            st_d.bd    = 1'b0;
            st_d.exl   = 1'b0;
            st_d.taken = 1'b1;
        end else if (any_pend) begin
            st_d.pc    = vec_pc;
            st_d.code  = win_code;
            st_d.exl   = 1'b1;
            st_d.taken = 1'b1;
            if (!st_q.exl) begin
                st_d.bd  = in_delay_slot_i;
                st_d.epc = in_delay_slot_i ? (fault_pc_i - INSN_SIZE) : fault_pc_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc    <= RESET_PC;
            st_q.epc   <= '0;
            st_q.code  <= '0;
            st_q.bd    <= 1'b0;
            st_q.exl   <= 1'b0;
            st_q.taken <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cause_o                     = '0;
        cause_o[BD_BIT]             = st_q.bd;
        cause_o[CODE_LSB +: CODE_W] = st_q.code;
    end

    assign taken_o  = st_q.taken;
    assign new_pc_o = st_q.pc;
    assign epc_o    = st_q.epc;
    assign exl_o    = st_q.exl;

    AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_i |=> (new_pc_o == RESET_PC) && !cause_o[BD_BIT] && !exl_o && taken_o); // R2
    AST_RESET_KEEPS_EPC: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_i |=> $stable(epc_o)); // R2
    AST_MCHECK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req_i && pend_i[EXC_MCHECK]) |=> (cause_o[CODE_LSB +: CODE_W] == CODE_W'(EXC_MCHECK))); // R3
    AST_EXC_RAISES_EXL: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req_i && (pend_i != '0)) |=> (exl_o && taken_o)); // R10
    AST_NESTED_KEEPS_EPC: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req_i && (pend_i != '0) && exl_o) |=> ($stable(epc_o) && $stable(cause_o[BD_BIT]))); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req_i && (pend_i == '0)) |=> (!taken_o && $stable(new_pc_o) && $stable(epc_o) && $stable(cause_o) && $stable(exl_o))); // R11
endmodule

// File: tb/exc_vector_unit_test.sv
module exc_vector_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_req_i = 1'b0;
    logic [31:0] pend_i = '0;
    logic [63:0] fault_pc_i = '0;
    logic        in_delay_slot_i = 1'b0;
    logic        tlb_refill_i = 1'b0;
    logic [1:0]  bad_seg_i = '0;
    logic        bev_i = 1'b0, iv_i = 1'b0, ux_i = 1'b0, sx_i = 1'b0, kx_i = 1'b0;
    logic        taken_o, bd_o_w, exl_o;
    logic [63:0] new_pc_o, epc_o;
    logic [31:0] cause_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] exp_epc;
    logic        exp_bd;
    logic [4:0]  exp_code;

    always #10 clk = ~clk;

    exc_vector_unit uut (
        .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req_i), .pend_i(pend_i),
        .fault_pc_i(fault_pc_i), .in_delay_slot_i(in_delay_slot_i),
        .tlb_refill_i(tlb_refill_i), .bad_seg_i(bad_seg_i), .bev_i(bev_i),
        .iv_i(iv_i), .ux_i(ux_i), .sx_i(sx_i), .kx_i(kx_i), .taken_o(taken_o),
        .new_pc_o(new_pc_o), .epc_o(epc_o), .cause_o(cause_o), .exl_o(exl_o)
    );

    assign bd_o_w = cause_o[31];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_vector(input int code, input bit refill, input bit exl,
                                               input bit iv, input bit bev, input int seg,
                                               input bit ux, input bit sx, input bit kx);
        logic [63:0] base;
        logic [63:0] off;
        bit ext;
        base = bev ? 64'hFFFF_FFFF_BFC0_0200 : 64'hFFFF_FFFF_8000_0000;
        ext  = (seg == 0 && ux) || (seg == 1 && sx) || (seg == 3 && kx);
        off  = 64'h180;
        if (code == 0 && iv) off = 64'h200;
        if ((code == 2 || code == 3) && refill && !exl) off = ext ? 64'h080 : 64'h000;
        if (code == 30) off = bev ? 64'h100 : 64'h2000_0100;
        return base + off;
    endfunction

    task automatic do_reset_req(input logic [31:0] also_pend, input bit check_it);
        @(negedge clk);
        rst_req_i = 1'b1;
        pend_i    = also_pend;
        @(negedge clk);
        rst_req_i = 1'b0;
        pend_i    = '0;
        exp_bd    = 1'b0;
        if (check_it) begin
            chk("R2 reset pc", new_pc_o, 64'hFFFF_FFFF_BFC0_0000);
            chk("R2 reset bd", {63'd0, bd_o_w}, 64'd0);
            chk("R2 reset exl", {63'd0, exl_o}, 64'd0);
            chk("R2 reset keeps epc", epc_o, exp_epc);
            chk("R3 reset beats pending code", {59'd0, cause_o[6:2]}, {59'd0, exp_code});
            chk("R2 reset taken", {63'd0, taken_o}, 64'd1);
        end
    endtask

    task automatic take(input logic [31:0] p, input logic [63:0] pc, input bit bd);
        @(negedge clk);
        pend_i = p;
        fault_pc_i = pc;
        in_delay_slot_i = bd;
        @(negedge clk);
        pend_i = '0;
    endtask

    initial begin
        exp_epc  = '0;
        exp_bd   = 1'b0;
        exp_code = '0;
        repeat (3) @(negedge clk);
        chk("R2 hw reset pc", new_pc_o, 64'hFFFF_FFFF_BFC0_0000);
        chk("R2 hw reset exl", {63'd0, exl_o}, 64'd0);
        chk("R2 hw reset taken", {63'd0, taken_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle after reset", {63'd0, taken_o}, 64'd0);

        // Reset request together with pending exceptions
        do_reset_req(32'h0100_0005, 1'b1);

        // Full sweep over code, base select, EXL state, delay slot, segment, refill, enables
        for (int code = 0; code < 32; code++) begin
            for (int cfg = 0; cfg < 512; cfg++) begin
                bit bev, exlpre, bd, refill, ux, sx, kx, iv;
                int seg;
                logic [63:0] pc, vec;
                bev = cfg[0]; exlpre = cfg[1]; bd = cfg[2]; refill = cfg[3];
                seg = (cfg >> 4) & 3; ux = cfg[6]; sx = cfg[7]; kx = cfg[8];
                iv = cfg[6] ^ cfg[2];
                if (code != 2 && code != 3 && (cfg[8:4] != 0) && cfg[6] == 1'b0) continue;
                do_reset_req('0, 1'b0);
                if (exlpre) begin
                    take(32'h0000_0040, 64'hFFFF_0000_0000_1000, 1'b1);
                    exp_epc = 64'hFFFF_0000_0000_0FFC;
                    exp_bd  = 1'b1;
                    chk("R9 first entry epc from delay slot", epc_o, exp_epc);
                end
                bev_i = bev; iv_i = iv; ux_i = ux; sx_i = sx; kx_i = kx;
                bad_seg_i = 2'(seg); tlb_refill_i = refill;
                pc  = 64'h0000_1234_0000_0000 + 64'(code * 4096 + cfg * 8);
                vec = exp_vector(code, refill, exlpre, iv, bev, seg, ux, sx, kx);
                take(32'd1 << code, pc, bd);
                if (!exlpre) begin
                    exp_epc = bd ? pc - 64'd4 : pc;
                    exp_bd  = bd;
                end
                exp_code = 5'(code);
                if (code == 0) chk("R4 interrupt vector", new_pc_o, vec);
                else if (code == 2 || code == 3) begin
                    if (refill && !exlpre) chk("R5 refill vector", new_pc_o, vec);
                    else chk("R6 tlb general vector", new_pc_o, vec);
                end
                else if (code == 30) chk("R7 cache error vector", new_pc_o, vec);
                else chk("R6 R8 general vector", new_pc_o, vec);
                chk("R1 code field", {59'd0, cause_o[6:2]}, {59'd0, exp_code});
                chk("R9 epc", epc_o, exp_epc);
                chk("R9 bd flag", {63'd0, bd_o_w}, {63'd0, exp_bd});
                chk("R10 exl set", {63'd0, exl_o}, 64'd1);
                chk("R10 taken pulse", {63'd0, taken_o}, 64'd1);
                @(negedge clk);
                chk("R11 idle holds pc", new_pc_o, vec);
                chk("R11 idle no pulse", {63'd0, taken_o}, 64'd0);
            end
        end

        // Priority among several pending bits
        for (int m = 1; m <= 300; m++) begin
            logic [31:0] mask;
            int lowest;
            mask = 32'(m) * 32'h9E37_79B1;
            if (mask == 0) mask = 32'h8000_0000;
            if (m % 3 == 0) mask = mask & ~(32'd1 << 24);
            lowest = 0;
            for (int k = 31; k >= 0; k--) if (mask[k]) lowest = k;
            if (mask[24]) lowest = 24;
            do_reset_req('0, 1'b0);
            take(mask, 64'h40, 1'b0);
            chk("R3 priority winner", {59'd0, cause_o[6:2]}, 64'(lowest));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule